// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus-facing half of a small serial non-volatile memory. It oversamples the two-wire clock and data lines with the system clock, recognises start and stop conditions, and shifts bytes in and out most significant bit first. It acknowledges its own traffic by pulling the data line low during the ninth clock. It decodes the device command byte and keeps the byte address counter. Written bytes are collected in a page buffer of eight slots. When the transfer ends, the block hands the page number, a mask of filled slots and the buffer contents to a separate programming controller. Reads are served from a combinational read port into the memory array, which the surrounding logic owns.

While the programming controller signals busy, the block refuses every command byte, so a master can poll with either a read or a write command until it sees an acknowledge. One size parameter selects the memory depth. The 256-byte build wraps a sequential read from the top address to zero. The 128-byte build holds the counter at its top address.

The controller is a single state machine. The states are IDLE, CMD, CMD_ACK, ADDR, ADDR_ACK, WDATA, WDATA_ACK, RDATA and RDATA_ACK. Its transitions are:
- A start condition moves any state to CMD.
- A stop condition moves any state to IDLE.
- CMD goes to CMD_ACK after a matching command byte taken while not busy, and to IDLE otherwise.
- CMD_ACK goes to ADDR for a write, or to RDATA for a read; entering RDATA loads the first byte.
- ADDR goes to ADDR_ACK, then to WDATA.
- WDATA goes to WDATA_ACK while the buffer has room, and to IDLE on the ninth byte; WDATA_ACK returns to WDATA.
- RDATA goes to RDATA_ACK after eight bits. RDATA_ACK goes back to RDATA when the master acknowledges, and to IDLE when it does not.

Top module: `eep_i2c_slave`

## Requirements
- R1: Out of reset `sda_oe` and `prog_req` are low. Bytes seen without a preceding start condition are ignored, and a stop condition ends any transfer.
- R2: A command byte whose bits 7..4 are 1010 is acknowledged whatever bits 3..1 hold. Bit 0 = 0 means write and bit 0 = 1 means read. Any other upper nibble is not acknowledged, and the bus is ignored until the next start condition.
- R3: The byte after a write command is acknowledged and loaded into the address counter. Its low log2(depth) bits are used, so bit 7 is ignored in the 128-byte build.
- R4: Each write data byte is acknowledged and stored in buffer slot address[2:0]. Only address bits 2..0 then increment, so entry wraps within the 8-byte page.
- R5: A ninth data byte in one transfer is not acknowledged and not stored.
- R6: A stop condition after at least one data byte raises `prog_req` for exactly one cycle. In that cycle `prog_page` is address[7:3] (address[6:3] in the 128-byte build), `prog_mask` bit i is set for each slot i that was filled, and slot i is `prog_data[8i+7:8i]`. A stop after only the address byte leaves `prog_req` low.
- R7: A read returns the byte at the counter, MSB first, and advances the counter by one per byte. A master acknowledge continues the read with the next byte; a master non-acknowledge ends it.
- R8: A repeated start with a read command after the address byte reads from the new address, and the abandoned write raises no request.
- R9: In the 256-byte build a sequential read continues from address 255 to 0. In the 128-byte build it stays at address 127.
- R10: While `prog_busy` is high, no command byte is acknowledged, whether it is a read or a write.
- R11: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High to pull the data line low |
| mem_addr | output | log2(MEM_BYTES) | Read address into the memory array (the address counter) |
| mem_rdata | input | 8 | Byte at `mem_addr`, combinational |
| prog_busy | input | 1 | Programming cycle in progress |
| prog_req | output | 1 | One-cycle request to program a page |
| prog_page | output | log2(MEM_BYTES)-3 | Page number of the request |
| prog_mask | output | 8 | Slots filled in this request |
| prog_data | output | 64 | Page buffer; slot i in bits 8i+7..8i |

## Verification
Two functions can land on the same clock edge: the busy flag from the programming controller falling, and the command-byte decision that samples it at the falling clock edge after the eighth bit. The bench provokes this with a loop of write-command polls. The polls run back to back right after a page request, so one of them straddles the end of the busy window. The bench records its own busy counter at the moment it drives that falling edge. Each poll's acknowledge must match that record; polls whose decision lies within the synchroniser delay of the busy edge are left unjudged.

// File: rtl/eep_pkg.sv
package eep_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD,
        S_CMD_ACK,
        S_ADDR,
        S_ADDR_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_RDATA,
        S_RDATA_ACK
    } eep_state_e;

    localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/eep_bus_cond.sv
module eep_bus_cond #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC-1:0] scl_q, sda_q;
    logic            scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[SYNC-2:0], scl_i};
            sda_q <= {sda_q[SYNC-2:0], sda_i};
            scl_p <= scl_q[SYNC-1];
            sda_p <= sda_q[SYNC-1];
        end
    end

    assign scl_s     = scl_q[SYNC-1];
    assign sda_s     = sda_q[SYNC-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/eep_addr_ctr.sv
module eep_addr_ctr #(
    parameter  int MEM_BYTES  = 256,
    parameter  int PAGE_BYTES = 8,
    localparam int AW         = $clog2(MEM_BYTES),
    localparam int PW         = $clog2(PAGE_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc_rd,
    input  logic          inc_wr,
    output logic [AW-1:0] addr
);
    localparam bit          ROLL     = (MEM_BYTES > 128);
    localparam logic [AW-1:0] TOP    = AW'(MEM_BYTES - 1);
    localparam logic [PW-1:0] ONE_LO = PW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (inc_wr) begin
            addr[PW-1:0] <= addr[PW-1:0] + ONE_LO;
        end else if (inc_rd) begin
            if (ROLL || addr != TOP) addr <= addr + AW'(1);
        end
    end

    // R4: page entry never disturbs the page bits
    a_r4_page_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_wr && !load) |=> $stable(addr[AW-1:PW]));

    // R9: the small build holds at the top address
    a_r9_no_roll: assert property (@(posedge clk) disable iff (!rst_n)
        (!ROLL && inc_rd && !load && !inc_wr && addr == TOP) |=> (addr == TOP));
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
    parameter  int PAGE_BYTES = 8,
    localparam int PW         = $clog2(PAGE_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    wr_en,
    input  logic [PW-1:0]           slot,
    input  logic [7:0]              wdata,
    output logic [PAGE_BYTES-1:0]   mask,
    output logic [8*PAGE_BYTES-1:0] data,
    output logic [PW:0]             count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      count <= '0;
        else if (clr)    count <= '0;
        else if (wr_en)  count <= count + 1'b1;
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask[g]        <= 1'b0;
                data[8*g +: 8] <= '0;
            end else if (clr) begin
                mask[g]        <= 1'b0;
            end else if (wr_en && slot == PW'(g)) begin
                mask[g]        <= 1'b1;
                data[8*g +: 8] <= wdata;
            end
        end
    end

    // R5: the controller never writes into a full page
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (count != (PW+1)'(PAGE_BYTES)));
endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave #(
    parameter  int MEM_BYTES  = 256,
    parameter  int PAGE_BYTES = 8,
    parameter  int SYNC       = 2,
    localparam int AW         = $clog2(MEM_BYTES),
    localparam int PW         = $clog2(PAGE_BYTES),
    localparam int PGW        = AW - PW
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    output logic                    sda_oe,
    output logic [AW-1:0]           mem_addr,
    input  logic [7:0]              mem_rdata,
    input  logic                    prog_busy,
    output logic                    prog_req,
    output logic [PGW-1:0]          prog_page,
    output logic [PAGE_BYTES-1:0]   prog_mask,
    output logic [8*PAGE_BYTES-1:0] prog_data
);
    import eep_pkg::*;

    eep_state_e state, nxt;
    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [3:0] bitcnt;
    logic [7:0] shreg;
    logic       sda_low, mack, wr_armed;
    logic [PGW-1:0] page_r;
    logic       ctr_load, ctr_inc_rd, ctr_inc_wr, buf_clr, buf_wr, issue;
    logic [PW:0] buf_count;

    eep_bus_cond #(.SYNC(SYNC)) u_cond (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    eep_addr_ctr #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load(ctr_load), .load_val(shreg[AW-1:0]),
        .inc_rd(ctr_inc_rd), .inc_wr(ctr_inc_wr), .addr(mem_addr)
    );

    eep_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(buf_wr),
        .slot(mem_addr[PW-1:0]), .wdata(shreg), .mask(prog_mask),
        .data(prog_data), .count(buf_count)
    );

    // next state and strobes
    always_comb begin
        nxt        = state;
        ctr_load   = 1'b0;
        ctr_inc_rd = 1'b0;
        ctr_inc_wr = 1'b0;
        buf_clr    = 1'b0;
        buf_wr     = 1'b0;
        issue      = 1'b0;
        if (start_det) begin
            nxt     = S_CMD;
            buf_clr = 1'b1;
        end else if (stop_det) begin
            nxt   = S_IDLE;
            issue = wr_armed;
        end else begin
            unique case (state)
                S_IDLE: ;
                S_CMD: if (scl_fall && bitcnt == 4'd8)
                    nxt = (shreg[7:4] == DEV_CODE && !prog_busy) ? S_CMD_ACK : S_IDLE;
                S_CMD_ACK: if (scl_fall) begin
                    if (shreg[0]) begin
                        nxt        = S_RDATA;
                        ctr_inc_rd = 1'b1;
                    end else begin
                        nxt = S_ADDR;
                    end
                end
                S_ADDR: if (scl_fall && bitcnt == 4'd8) begin
                    nxt      = S_ADDR_ACK;
                    ctr_load = 1'b1;
                end
                S_ADDR_ACK: if (scl_fall) nxt = S_WDATA;
                S_WDATA: if (scl_fall && bitcnt == 4'd8) begin
                    if (buf_count != (PW+1)'(PAGE_BYTES)) begin
                        nxt        = S_WDATA_ACK;
                        buf_wr     = 1'b1;
                        ctr_inc_wr = 1'b1;
                    end else begin
                        nxt = S_IDLE;
                    end
                end
                S_WDATA_ACK: if (scl_fall) nxt = S_WDATA;
                S_RDATA: if (scl_fall && bitcnt == 4'd8) nxt = S_RDATA_ACK;
                S_RDATA_ACK: if (scl_fall) begin
                    if (mack) begin
                        nxt        = S_RDATA;
                        ctr_inc_rd = 1'b1;
                    end else begin
                        nxt = S_IDLE;
                    end
                end
                default: nxt = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // shifter, line drive and request outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt   <= '0;
            shreg    <= '0;
            sda_low  <= 1'b0;
            mack     <= 1'b0;
            wr_armed <= 1'b0;
            page_r   <= '0;
            prog_req <= 1'b0;
        end else begin
            prog_req <= issue;
            if (ctr_load) page_r <= shreg[AW-1:PW];
            if (start_det || stop_det) wr_armed <= 1'b0;
            else if (buf_wr)           wr_armed <= 1'b1;

            if (start_det || stop_det) begin
                bitcnt  <= '0;
                sda_low <= 1'b0;
            end else begin
                unique case (state)
                    S_CMD, S_ADDR, S_WDATA: begin
                        if (scl_rise && bitcnt != 4'd8) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            bitcnt  <= '0;
                            sda_low <= (nxt != S_IDLE);
                        end
                    end
                    S_CMD_ACK, S_ADDR_ACK, S_WDATA_ACK, S_RDATA_ACK: begin
                        if (state == S_RDATA_ACK && scl_rise) mack <= ~sda_s;
                        if (scl_fall) begin
                            if (nxt == S_RDATA) begin
                                shreg   <= mem_rdata;
                                sda_low <= ~mem_rdata[7];
                            end else begin
                                sda_low <= 1'b0;
                            end
                        end
                    end
                    S_RDATA: begin
                        if (scl_rise && bitcnt != 4'd8) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                bitcnt  <= '0;
                                sda_low <= 1'b0;
                            end else begin
                                shreg   <= {shreg[6:0], 1'b0};
                                sda_low <= ~shreg[6];
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe    = sda_low;
    assign prog_page = page_r;

    // R10: a command is only acknowledged when busy was low at the decision
    a_r10_busy_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CMD_ACK && $past(state) == S_CMD) |-> !$past(prog_busy));

    // R6: the request is a single-cycle pulse
    a_r6_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> !prog_req);

    // R6: a request always carries at least one filled slot
    a_r6_req_mask: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> (prog_mask != '0));

    // R11: the line drive moves only in the low phase of SCL
    a_r11_drive_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);
endmodule

// File: tb/test_eep_i2c_slave.sv
`timescale 1ns/1ps
module test_eep_i2c_slave;
    localparam int H        = 10;
    localparam int PROG_CYC = 2000;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1, sel = 1'b0;
    logic sda_line, scl_b, sdai_b, scl_s, sdai_s;
    logic oe_b, oe_s;
    logic [7:0] addr_b, rdata_b, rdata_s;
    logic [6:0] addr_s;
    logic busy_b, req_b, req_s;
    logic [4:0] page_b;
    logic [3:0] page_s;
    logic [7:0] mask_b, mask_s;
    logic [63:0] data_b, data_s;

    logic [7:0] mem_b [256];
    logic [7:0] mem_s [128];

    int checks = 0, errors = 0;
    int busy_cnt = 0, req_cnt = 0, dec_cnt = 0, viol = 0;
    logic [4:0]  last_page;
    logic [7:0]  last_mask;
    logic [63:0] last_data;

    assign sda_line = m_sda & ~(sel ? oe_s : oe_b);
    assign scl_b    = sel ? 1'b1 : m_scl;
    assign sdai_b   = sel ? 1'b1 : sda_line;
    assign scl_s    = sel ? m_scl : 1'b1;
    assign sdai_s   = sel ? sda_line : 1'b1;
    assign rdata_b  = mem_b[addr_b];
    assign rdata_s  = mem_s[addr_s];
    assign busy_b   = (busy_cnt != 0);

    eep_i2c_slave #(.MEM_BYTES(256)) i_eep_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_b), .sda_i(sdai_b), .sda_oe(oe_b),
        .mem_addr(addr_b), .mem_rdata(rdata_b), .prog_busy(busy_b),
        .prog_req(req_b), .prog_page(page_b), .prog_mask(mask_b), .prog_data(data_b)
    );

    eep_i2c_slave #(.MEM_BYTES(128)) i_eep_i2c_slave_small (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_s), .sda_i(sdai_s), .sda_oe(oe_s),
        .mem_addr(addr_s), .mem_rdata(rdata_s), .prog_busy(1'b0),
        .prog_req(req_s), .prog_page(page_s), .prog_mask(mask_s), .prog_data(data_s)
    );

    // programming controller model for the large instance
    always @(posedge clk) begin
        if (req_b) begin
            for (int i = 0; i < 8; i++)
                if (mask_b[i]) mem_b[{page_b, 3'(i)}] = data_b[8*i +: 8];
            req_cnt   = req_cnt + 1;
            last_page = page_b;
            last_mask = mask_b;
            last_data = data_b;
            busy_cnt  = PROG_CYC;
        end else if (busy_cnt != 0) begin
            busy_cnt = busy_cnt - 1;
        end
    end

    // R11 monitor: the slave may only move its drive while SCL is low
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && (sel ? oe_s : oe_b) != oe_prev && m_scl) viol++;
        oe_prev = sel ? oe_s : oe_b;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard: driver pushes expectations, monitor compares read bytes
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] got;
    event       got_ev;
    always begin
        @(got_ev);
        if (exp_q.size() == 0) chk(1'b0, "scoreboard empty", got, 0);
        else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(got == e, t, got, e);
        end
    end

    task automatic wh(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_scl = 1'b0; wh(H/2); m_sda = 1'b1; wh(H/2);
        m_scl = 1'b1; wh(H);   m_sda = 1'b0; wh(H);
    endtask

    task automatic bus_stop();
        m_scl = 1'b0; wh(H/2); m_sda = 1'b0; wh(H/2);
        m_scl = 1'b1; wh(H);   m_sda = 1'b1; wh(H);
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_scl = 1'b0; wh(H/2); m_sda = b[i]; wh(H/2);
            m_scl = 1'b1; wh(H);
        end
        m_scl = 1'b0; dec_cnt = busy_cnt; wh(H/2); m_sda = 1'b1; wh(H/2);
        m_scl = 1'b1; wh(H/2); ack = ~sda_line; wh(H/2);
    endtask

    task automatic rbyte(input logic mack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            m_scl = 1'b0; m_sda = 1'b1; wh(H);
            m_scl = 1'b1; wh(H/2); v[i] = sda_line; wh(H/2);
        end
        m_scl = 1'b0; wh(H/2); m_sda = ~mack; wh(H/2);
        m_scl = 1'b1; wh(H);
    endtask

    task automatic rd_expect(input logic mack, input logic [7:0] e, input string t);
        logic [7:0] v;
        exp_q.push_back(e);
        tag_q.push_back(t);
        rbyte(mack, v);
        got = v;
        ->got_ev;
        wh(1);
    endtask

    task automatic wait_idle();
        while (busy_cnt != 0) @(negedge clk);
        wh(4);
    endtask

    initial begin
        logic ack;
        int   rq;
        for (int i = 0; i < 256; i++) mem_b[i] = 8'(i) ^ 8'h5A;
        for (int i = 0; i < 128; i++) mem_s[i] = 8'(i) ^ 8'hA5;
        wh(5);
        chk(oe_b == 1'b0 && req_b == 1'b0, "R1 reset outputs", {oe_b, req_b}, 0);
        rst_n = 1'b1;
        wh(5);

        // R2 wrong device code, then R1 a valid command with no START is ignored
        bus_start();
        wbyte(8'hB0, ack); chk(ack == 1'b0, "R2 foreign code NACK", ack, 0);
        wbyte(8'hA0, ack); chk(ack == 1'b0, "R1 ignored until START", ack, 0);
        bus_stop();

        // R2/R3/R4 write with don't-care bits set, wrapping inside page 7
        bus_start();
        wbyte(8'hAE, ack); chk(ack == 1'b1, "R2 write command ACK", ack, 1);
        wbyte(8'h3D, ack); chk(ack == 1'b1, "R3 address ACK", ack, 1);
        wbyte(8'h11, ack); chk(ack == 1'b1, "R4 data ACK", ack, 1);
        wbyte(8'h22, ack);
        wbyte(8'h33, ack);
        wbyte(8'h44, ack); chk(ack == 1'b1, "R4 wrapped data ACK", ack, 1);
        rq = req_cnt;
        bus_stop();
        chk(req_cnt == rq + 1, "R6 one request", req_cnt, rq + 1);
        chk(last_page == 5'd7, "R6 page", last_page, 7);
        chk(last_mask == 8'hE1, "R4 slot mask", last_mask, 8'hE1);
        chk(last_data[47:40] == 8'h11 && last_data[7:0] == 8'h44, "R4 slot data",
            {last_data[47:40], last_data[7:0]}, 16'h1144);

        // R10 polling while busy, read and write commands
        bus_start();
        wbyte(8'hA1, ack); chk(ack == 1'b0, "R10 read poll NACK", ack, 0);
        bus_start();
        wbyte(8'hA0, ack); chk(ack == 1'b0, "R10 write poll NACK", ack, 0);
        // busy window ends during this loop
        for (int n = 0; n < 40; n++) begin
            bus_start();
            wbyte(8'hA0, ack);
            if (dec_cnt == 0 || dec_cnt > 8)
                chk(ack == (dec_cnt == 0), "R10 poll vs busy", ack, dec_cnt == 0);
            if (ack) break;
        end
        bus_stop();
        wait_idle();

        // R7 current address read: counter ended at 0x39 after the wrap
        bus_start();
        wbyte(8'hA1, ack); chk(ack == 1'b1, "R2 read command ACK", ack, 1);
        rd_expect(1'b0, mem_b[8'h39], "R7 current address read");
        bus_stop();

        // R8 random read through a repeated START, sequential across a page edge
        rq = req_cnt;
        bus_start();
        wbyte(8'hA0, ack);
        wbyte(8'h3D, ack);
        bus_start();
        wbyte(8'hA1, ack);
        rd_expect(1'b1, 8'h11, "R8 random read");
        rd_expect(1'b1, 8'h22, "R7 sequential");
        rd_expect(1'b1, 8'h33, "R7 sequential");
        rd_expect(1'b0, mem_b[8'h40], "R7 next page");
        bus_stop();
        chk(req_cnt == rq, "R8 abandoned write no request", req_cnt, rq);

        // R6 address-only write sets counter without a request
        bus_start();
        wbyte(8'hA0, ack);
        wbyte(8'h80, ack);
        bus_stop();
        chk(req_cnt == rq, "R6 address only no request", req_cnt, rq);
        bus_start();
        wbyte(8'hA1, ack);
        rd_expect(1'b0, mem_b[8'h80], "R3 counter loaded");
        bus_stop();

        // R5 nine data bytes into page 2
        bus_start();
        wbyte(8'hA0, ack);
        wbyte(8'h10, ack);
        for (int i = 0; i < 8; i++) wbyte(8'hC0 + 8'(i), ack);
        chk(ack == 1'b1, "R4 eighth byte ACK", ack, 1);
        wbyte(8'hC8, ack); chk(ack == 1'b0, "R5 ninth byte NACK", ack, 0);
        bus_stop();
        chk(last_mask == 8'hFF && last_page == 5'd2, "R6 full page request",
            {last_page, last_mask}, {5'd2, 8'hFF});
        chk(last_data[7:0] == 8'hC0, "R5 ninth byte not stored", last_data[7:0], 8'hC0);
        wait_idle();
        bus_start();
        wbyte(8'hA0, ack);
        wbyte(8'h10, ack);
        bus_start();
        wbyte(8'hA1, ack);
        rd_expect(1'b1, 8'hC0, "R6 programmed slot 0");
        rd_expect(1'b0, 8'hC1, "R6 programmed slot 1");
        bus_stop();

        // R9 rollover in the large build
        bus_start();
        wbyte(8'hA0, ack);
        wbyte(8'hFF, ack);
        bus_start();
        wbyte(8'hA1, ack);
        rd_expect(1'b1, mem_b[8'hFF], "R9 top address");
        rd_expect(1'b0, mem_b[8'h00], "R9 rollover to 0");
        bus_stop();

        // R9/R3 small build: bit 7 of address ignored, no rollover
        sel = 1'b1;
        wh(4);
        bus_start();
        wbyte(8'hA0, ack); chk(ack == 1'b1, "R2 small build ACK", ack, 1);
        wbyte(8'hFF, ack);
        bus_start();
        wbyte(8'hA1, ack);
        rd_expect(1'b1, mem_s[7'h7F], "R3 small address 7 bits");
        rd_expect(1'b1, mem_s[7'h7F], "R9 small holds at top");
        rd_expect(1'b0, mem_s[7'h7F], "R9 small holds at top");
        bus_stop();
        sel = 1'b0;
        wh(10);

        chk(viol == 0, "R11 drive change with SCL high", viol, 0);
        chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule